// File: doc/BRIEF.md
# T1 Bit-Oriented Code Detector

This block watches the received data-link bit stream of a T1 extended-superframe receiver for bit-oriented code messages. A message is sixteen data-link bits long and carries a 6-bit code. The block reports a code as detected only after the same code has arrived in enough back-to-back messages. After that it tracks the code until messages carrying it stop for a programmable number of data-link bits.

Software sees the latched code, a sticky "code found" bit, a sticky "code lost" bit and an active-low interrupt request. The two status bits are cleared by write-one-to-clear strobes and enabled onto the interrupt by a two-bit enable register. A 4-bit control word sets the qualification count (bits 1:0) and the loss interval (bits 3:2). Frame alignment, HDLC reception and address decoding are handled elsewhere.

The control state machine has two states. ST_IDLE means no code is held. ST_ACTIVE means a code is held and its loss timer runs. ACQUIRE (ST_IDLE to ST_ACTIVE) happens when a candidate code qualifies. REFRESH (stays in ST_ACTIVE) happens when a message matches the held code and restarts the loss timer. REPLACE (stays in ST_ACTIVE) happens when a different code qualifies and takes the place of the held code. EXPIRE (ST_ACTIVE to ST_IDLE) happens when the loss timer reaches its limit. DISABLE (any state to ST_IDLE) happens while extended-superframe mode is off.

Top module: `t1_boc_detect`

## Requirements
- R1: Bits are examined only on cycles where `esf_mode`=1 and `dl_strobe`=1. While `esf_mode`=0, the bit window, the qualification count and the loss timer are emptied and the machine returns to ST_IDLE. `code_out`, `found` and `lost` keep their values while this happens.
- R2: On every strobe the 16 most recent bits, oldest first, are tested for this sequence: eight 1s, one 0, six code bits, one 0. Any other sequence is not a message.
- R3: The six code bits arrive least significant bit first, so `code_out[i]` is the i-th code bit received. `code_out` changes only on ACQUIRE or REPLACE.
- R4: Two messages are consecutive when the second ends exactly 16 strobes after the first. The number of consecutive identical messages needed to qualify is 1, 3, 5 or 7 for `ctrl[1:0]` = 0, 1, 2 or 3. `found` is visible one clock after the strobe that completes the qualifying message.
- R5: In ST_ACTIVE, `lost` is set and the machine takes EXPIRE after 16, 32, 48 or 64 strobes (for `ctrl[3:2]` = 0, 1, 2 or 3) with no message matching `code_out`. Each REFRESH restarts this count.
- R6: While a code is held, repeated messages carrying that code never set `found` again. `found` is set again only by REPLACE with a different code, or by ACQUIRE after EXPIRE.
- R7: `found` and `lost` are sticky. `clr_wr`=1 clears `found` where `clr_data[0]`=1 and clears `lost` where `clr_data[1]`=1. A set in the same cycle wins over the clear.
- R8: `irq_n` is 0 exactly while (`found` and enable bit 0) or (`lost` and enable bit 1). `en_wr`=1 loads `en_data` into the enable register.
- R9: After reset, `code_out`=0, `found`=0, `lost`=0, the enables are 0, `irq_n`=1 and the machine is in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| esf_mode | input | 1 | Receiver is in extended-superframe mode |
| dl_bit | input | 1 | Recovered data-link bit |
| dl_strobe | input | 1 | One-cycle strobe marking a valid `dl_bit` |
| ctrl | input | 4 | [1:0] qualification count select, [3:2] loss interval select |
| clr_wr | input | 1 | Status clear strobe |
| clr_data | input | 2 | Write-one-to-clear: bit 0 found, bit 1 lost |
| en_wr | input | 1 | Interrupt enable write strobe |
| en_data | input | 2 | Enable value: bit 0 found, bit 1 lost |
| code_out | output | 6 | Latched code |
| found | output | 1 | Sticky code-found status |
| lost | output | 1 | Sticky code-lost status |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `dl_strobe` and `esf_mode` are held low during reset. They also assume that a status bit can rise only in a cycle that follows an enabled strobe, so the inputs must change only between clock edges and never within one. The bench drives every input at the falling edge, holds each strobe for exactly one cycle and keeps all inputs quiet during reset. Its random phase mixes whole messages from a small code pool, random noise bits and clear strobes that land on the same cycle as strobes, together with occasional changes to the control word, the enables and the mode.

// File: rtl/t1boc_pkg.sv
package t1boc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } boc_state_e;

    // Consecutive identical messages required: 2*sel + 1.
    function automatic logic [3:0] filter_count(input logic [1:0] sel);
        return {1'b0, sel, 1'b1};
    endfunction

endpackage

// File: rtl/boc_window_match.sv
module boc_window_match #(
    parameter int MSG_W    = 16,
    parameter int CODE_W   = 6,
    parameter int PREAMBLE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              strobe,
    input  logic              bit_in,
    output logic              hit,
    output logic [CODE_W-1:0] code
);

    localparam int ZERO_POS = MSG_W - 1 - PREAMBLE;

    logic [MSG_W-2:0] hist_q;
    logic [MSG_W-1:0] win;

    assign win = {hist_q, bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (!enable) begin
            hist_q <= '0;
        end else if (strobe) begin
            hist_q <= win[MSG_W-2:0];
        end
    end

    assign hit = enable && strobe
               && (&win[MSG_W-1 -: PREAMBLE])
               && !win[ZERO_POS]
               && !win[0];

    // Code arrives LSB first: first code bit sits just below the separator zero.
    for (genvar gi = 0; gi < CODE_W; gi++) begin : g_code
        assign code[gi] = win[ZERO_POS-1-gi];
    end

endmodule

// File: rtl/boc_qualifier.sv
module boc_qualifier #(
    parameter int MSG_W  = 16,
    parameter int CODE_W = 6,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              strobe,
    input  logic              hit,
    input  logic [CODE_W-1:0] code,
    input  logic [CNT_W-1:0]  need,
    output logic              qualify
);

    localparam int GAP_W   = $clog2(MSG_W + 1);
    localparam int CNT_MAX = 2 ** (CNT_W - 1);

    logic [GAP_W-1:0]  gap_q;
    logic [CODE_W-1:0] cand_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_next;
    logic              back_to_back;

    assign back_to_back = (gap_q == GAP_W'(MSG_W - 1)) && (code == cand_q);

    always_comb begin
        if (!back_to_back) begin
            cnt_next = CNT_W'(1);
        end else if (cnt_q == CNT_W'(CNT_MAX)) begin
            cnt_next = cnt_q;
        end else begin
            cnt_next = cnt_q + 1'b1;
        end
    end

    assign qualify = hit && (cnt_next == need);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            cand_q <= '0;
            cnt_q  <= '0;
        end else if (!enable) begin
            gap_q  <= '0;
            cand_q <= '0;
            cnt_q  <= '0;
        end else if (strobe) begin
            if (hit) begin
                gap_q  <= '0;
                cand_q <= code;
                cnt_q  <= cnt_next;
            end else if (gap_q != GAP_W'(MSG_W)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/boc_status.sv
module boc_status #(
    parameter int N_STAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_STAT-1:0] set,
    input  logic              clr_wr,
    input  logic [N_STAT-1:0] clr_data,
    input  logic              en_wr,
    input  logic [N_STAT-1:0] en_data,
    output logic [N_STAT-1:0] stat,
    output logic              irq_n
);

    logic [N_STAT-1:0] en_q;

    for (genvar gi = 0; gi < N_STAT; gi++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat[gi] <= 1'b0;
            end else if (set[gi]) begin
                stat[gi] <= 1'b1;
            end else if (clr_wr && clr_data[gi]) begin
                stat[gi] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_data;
        end
    end

    assign irq_n = ~|(stat & en_q);

endmodule

// File: rtl/t1_boc_detect.sv
module t1_boc_detect
    import t1boc_pkg::*;
#(
    parameter int MSG_W      = 16,
    parameter int CODE_W     = 6,
    parameter int PREAMBLE   = 8,
    parameter int CNT_W      = 4,
    parameter int BLOCK_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              esf_mode,
    input  logic              dl_bit,
    input  logic              dl_strobe,
    input  logic [3:0]        ctrl,
    input  logic              clr_wr,
    input  logic [1:0]        clr_data,
    input  logic              en_wr,
    input  logic [1:0]        en_data,
    output logic [CODE_W-1:0] code_out,
    output logic              found,
    output logic              lost,
    output logic              irq_n
);

    localparam int DIS_W = $clog2(4 * BLOCK_BITS + 1);

    boc_state_e        state_q, state_d;
    logic [DIS_W-1:0]  dis_q, dis_d, dis_limit;
    logic [CODE_W-1:0] code_q, code_d;
    logic              hit, qualify, set_found, set_lost;
    logic [CODE_W-1:0] rx_code;
    logic [1:0]        stat;

    boc_window_match #(
        .MSG_W(MSG_W), .CODE_W(CODE_W), .PREAMBLE(PREAMBLE)
    ) u_win (
        .clk(clk), .rst_n(rst_n), .enable(esf_mode), .strobe(dl_strobe),
        .bit_in(dl_bit), .hit(hit), .code(rx_code)
    );

    boc_qualifier #(
        .MSG_W(MSG_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
    ) u_qual (
        .clk(clk), .rst_n(rst_n), .enable(esf_mode), .strobe(dl_strobe),
        .hit(hit), .code(rx_code),
        .need(CNT_W'(filter_count(ctrl[1:0]))), .qualify(qualify)
    );

    assign dis_limit = DIS_W'(BLOCK_BITS * (int'(ctrl[3:2]) + 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dis_q   <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            dis_q   <= dis_d;
            code_q  <= code_d;
        end
    end

    // Next state and event outputs
    always_comb begin
        state_d   = state_q;
        dis_d     = dis_q;
        code_d    = code_q;
        set_found = 1'b0;
        set_lost  = 1'b0;
        if (!esf_mode) begin
            state_d = ST_IDLE;                      // DISABLE
            dis_d   = '0;
        end else if (dl_strobe) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (qualify) begin              // ACQUIRE
                        state_d   = ST_ACTIVE;
                        code_d    = rx_code;
                        set_found = 1'b1;
                        dis_d     = '0;
                    end
                end
                ST_ACTIVE: begin
                    if (hit && rx_code == code_q) begin
                        dis_d = '0;                 // REFRESH
                    end else if (qualify) begin     // REPLACE
                        code_d    = rx_code;
                        set_found = 1'b1;
                        dis_d     = '0;
                    end else if (dis_q + 1'b1 == dis_limit) begin
                        state_d  = ST_IDLE;         // EXPIRE
                        set_lost = 1'b1;
                        dis_d    = '0;
                    end else begin
                        dis_d = dis_q + 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    boc_status #(.N_STAT(2)) u_stat (
        .clk(clk), .rst_n(rst_n), .set({set_lost, set_found}),
        .clr_wr(clr_wr), .clr_data(clr_data), .en_wr(en_wr),
        .en_data(en_data), .stat(stat), .irq_n(irq_n)
    );

    assign code_out = code_q;
    assign found    = stat[0];
    assign lost     = stat[1];

endmodule

// File: rtl/t1_boc_detect_chk.sv
module t1_boc_detect_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              esf_mode,
    input logic              dl_strobe,
    input logic              clr_wr,
    input logic [1:0]        clr_data,
    input logic [CODE_W-1:0] code_out,
    input logic              found,
    input logic              lost,
    input logic              irq_n
);

    AST_NO_SET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dl_strobe && esf_mode) |-> !$rose(found) && !$rose(lost)); // R1

    AST_CODE_CHANGES_ON_FIND: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_out) |-> found); // R3

    AST_FIND_LOSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(found) && $rose(lost))); // R5

    AST_FOUND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        found && !(clr_wr && clr_data[0]) |=> found); // R7

    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lost && !(clr_wr && clr_data[1]) |=> lost); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !found && !lost |-> irq_n); // R8

endmodule

bind t1_boc_detect t1_boc_detect_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .dl_strobe(dl_strobe),
    .clr_wr(clr_wr), .clr_data(clr_data), .code_out(code_out),
    .found(found), .lost(lost), .irq_n(irq_n)
);

// File: tb/tb_t1_boc_detect.sv
module tb_t1_boc_detect;

    logic       clk = 1'b0, rst_n = 1'b0, esf_mode = 1'b0, dl_bit = 1'b0;
    logic       dl_strobe = 1'b0, clr_wr = 1'b0, en_wr = 1'b0;
    logic [3:0] ctrl = '0;
    logic [1:0] clr_data = '0, en_data = '0;
    logic [5:0] code_out;
    logic       found, lost, irq_n;

    always #5 clk = ~clk;

    t1_boc_detect dut (
        .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .dl_bit(dl_bit),
        .dl_strobe(dl_strobe), .ctrl(ctrl), .clr_wr(clr_wr), .clr_data(clr_data),
        .en_wr(en_wr), .en_data(en_data), .code_out(code_out), .found(found),
        .lost(lost), .irq_n(irq_n)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference model state
    logic [15:0] m_win = '0;
    int          m_gap = 0, m_cnt = 0, m_dis = 0;
    logic [5:0]  m_cand = '0, m_code = '0;
    bit          m_act = 0, m_found = 0, m_lost = 0;
    logic [1:0]  m_en = '0;

    function automatic bit exp_irq_n();
        return !((m_found && m_en[0]) || (m_lost && m_en[1]));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3 code_out", code_out, m_code);
        chk("R4 found", found, m_found);
        chk("R5 lost", lost, m_lost);
        chk("R8 irq_n", irq_n, exp_irq_n());
    endtask

    task automatic model_disable();
        m_win = '0; m_gap = 0; m_cnt = 0; m_cand = '0; m_act = 0; m_dis = 0;
    endtask

    task automatic model_clear(input logic [1:0] d);
        if (d[0]) m_found = 0;
        if (d[1]) m_lost = 0;
    endtask

    task automatic model_step(input logic b);
        logic [5:0] c;
        bit v, q;
        int need, lim;
        need = 2 * int'(ctrl[1:0]) + 1;
        lim  = 16 * (int'(ctrl[3:2]) + 1);
        m_win = {m_win[14:0], b};
        v = (m_win[15:8] == 8'hFF) && !m_win[7] && !m_win[0];
        for (int i = 0; i < 6; i++) c[i] = m_win[6-i];
        q = 0;
        if (v) begin
            if (m_gap == 15 && c == m_cand) m_cnt = (m_cnt < 8) ? m_cnt + 1 : 8;
            else begin m_cand = c; m_cnt = 1; end
            m_gap = 0;
            q = (m_cnt == need);
        end else if (m_gap < 16) begin
            m_gap++;
        end
        if (m_act) begin
            if (v && c == m_code) m_dis = 0;
            else if (q) begin m_code = c; m_found = 1; m_dis = 0; end
            else begin
                m_dis++;
                if (m_dis == lim) begin m_lost = 1; m_act = 0; m_dis = 0; end
            end
        end else if (q) begin
            m_act = 1; m_code = c; m_found = 1; m_dis = 0;
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic send_bit(input logic b, input logic clr, input logic [1:0] cd);
        dl_bit = b; dl_strobe = 1'b1; clr_wr = clr; clr_data = cd;
        @(negedge clk);
        if (clr) model_clear(cd);
        if (esf_mode) model_step(b); else model_disable();
        dl_strobe = 1'b0; clr_wr = 1'b0;
        compare_all();
    endtask

    task automatic send_msg(input logic [5:0] c);
        for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0, 2'b00);
        send_bit(1'b0, 1'b0, 2'b00);
        for (int i = 0; i < 6; i++) send_bit(c[i], 1'b0, 2'b00);
        send_bit(1'b0, 1'b0, 2'b00);
    endtask

    task automatic do_clear(input logic [1:0] d);
        clr_wr = 1'b1; clr_data = d;
        @(negedge clk);
        clr_wr = 1'b0; model_clear(d);
        compare_all();
    endtask

    task automatic write_en(input logic [1:0] d);
        en_wr = 1'b1; en_data = d;
        @(negedge clk);
        en_wr = 1'b0; m_en = d;
        compare_all();
    endtask

    task automatic set_esf(input logic v);
        esf_mode = v;
        @(negedge clk);
        if (!v) model_disable();
        compare_all();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R4 watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [5:0] pool [4];
        int r;
        pool[0] = 6'h25; pool[1] = 6'h3A; pool[2] = 6'h00; pool[3] = 6'h3F;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 code_out", code_out, 0);
        chk("R9 found", found, 0);
        chk("R9 lost", lost, 0);
        chk("R9 irq_n", irq_n, 1);

        set_esf(1'b1);
        write_en(2'b11);
        // R2: bad closing bit is not a message
        for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0, 2'b00);
        send_bit(1'b0, 1'b0, 2'b00);
        for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b0, 2'b00);
        send_bit(1'b1, 1'b0, 2'b00);
        chk("R2 no find on bad frame", found, 0);
        send_msg(6'h25);
        chk("R2 find on good frame", found, 1);
        chk("R3 code lsb first", code_out, 6'h25);
        chk("R8 irq on find", irq_n, 0);
        repeat (3) send_msg(6'h25);
        do_clear(2'b01);
        repeat (2) send_msg(6'h25);
        chk("R6 same code no refind", found, 0);
        // R5 loss after 16 empty strobes
        repeat (15) send_bit(1'b0, 1'b0, 2'b00);
        chk("R5 not yet lost", lost, 0);
        send_bit(1'b0, 1'b0, 2'b00);
        chk("R5 lost at limit", lost, 1);
        write_en(2'b00);
        chk("R8 masked irq", irq_n, 1);
        do_clear(2'b11);
        chk("R7 cleared found", found, 0);
        chk("R7 cleared lost", lost, 0);
        write_en(2'b11);
        // R4 filter of seven
        ctrl = 4'b0011;
        repeat (6) send_msg(6'h3A);
        chk("R4 six of seven", found, 0);
        send_msg(6'h3A);
        chk("R4 seventh qualifies", found, 1);
        // R6 replacement by a different code
        ctrl = 4'b1101;
        do_clear(2'b01);
        repeat (2) send_msg(6'h11);
        chk("R6 two of three", found, 0);
        send_msg(6'h11);
        chk("R6 replace found", found, 1);
        chk("R6 replace code", code_out, 6'h11);
        // R1 disabled mode ignores messages
        set_esf(1'b0);
        do_clear(2'b11);
        repeat (3) send_msg(6'h07);
        chk("R1 no find when off", found, 0);
        chk("R1 code held when off", code_out, 6'h11);
        set_esf(1'b1);
        repeat (2) send_msg(6'h07);
        chk("R1 restart count", found, 0);
        send_msg(6'h07);
        chk("R1 find after enable", found, 1);
        // R7 set wins over clear in the same cycle
        ctrl = 4'b0000;
        do_clear(2'b11);
        for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0, 2'b00);
        send_bit(1'b0, 1'b0, 2'b00);
        for (int i = 0; i < 6; i++) send_bit(i[0], 1'b0, 2'b00);
        send_bit(1'b0, 1'b1, 2'b01);
        chk("R7 set beats clear", found, 1);

        // Random phase
        for (int it = 0; it < 2500; it++) begin
            if ($urandom % 40 == 0) ctrl = 4'($urandom);
            if ($urandom % 120 == 0) set_esf(1'b0);
            else if (!esf_mode && $urandom % 4 == 0) set_esf(1'b1);
            r = $urandom % 10;
            if (r < 6) send_msg(pool[$urandom % 4]);
            else if (r < 8) begin
                for (int k = 0; k < 1 + int'($urandom % 20); k++)
                    send_bit(1'($urandom), ($urandom % 8) == 0, 2'($urandom));
            end else if (r == 8) do_clear(2'($urandom));
            else write_en(2'($urandom));
        end

        done = 1;
        finish_run();
    end

endmodule